// File: doc/BRIEF.md
# Periodic Count-Pulse Timer with Zero Detect

This block generates the periodic requests that drive four software-visible time counters, and performs the decrement-and-test step when one of those requests is serviced. Two fixed-rate ticks (500 Hz and 2000 Hz) are derived from the system clock by prescalers. Two asynchronous inputs are also accepted: a mains line-frequency signal and a free external pulse. Counters 1 to 3 each pick one of these four sources through their own 2-bit select. Counter 4 always runs from the 500 Hz tick. Each selected tick emits a single-cycle request on that counter's output.

When the surrounding interrupt logic services a request, it presents the counter's stored value on the acknowledge port, along with the counter index and a service mode. The mode picks one of three things: decrement the low byte, decrement the low halfword, or decrement the whole word. A fourth mode passes the value through unchanged. One cycle later the block returns the modified value. If the decremented field reached zero, it also pulses the zero request belonging to that counter. Counter 4 must be serviced by a decrement. Servicing it in the pass-through mode raises an exception flag instead.

Top module: `cpt_timer`

## Requirements
- R1: While rst_n is low at a clock edge, pulse_req, zero_req, res_valid, res_data and exc_flag are all zero after that edge.
- R2: pulse_req[3] is a one-cycle pulse repeating every CLK_HZ/500 clock cycles, whatever the value of src_sel.
- R3: The 2000 Hz source repeats every CLK_HZ/2000 clock cycles as a one-cycle pulse.
- R4: src_sel[2k+1:2k] selects the source of pulse_req[k] for k = 0..2: 00 line input, 01 500 Hz tick, 10 2000 Hz tick, 11 external input. A counter whose source is idle produces no pulses.
- R5: Each low-to-high transition of line_in or ext_in (held at least 2 cycles in each level) produces exactly one pulse on every counter that selects it.
- R6: ack_mode 00 (byte): res_data one cycle after ack_valid is ack_opnd with bits [7:0] decremented modulo 256 and bits [31:8] unchanged.
- R7: ack_mode 01 (halfword): bits [15:0] decremented modulo 65536, bits [31:16] unchanged.
- R8: ack_mode 10 (word): all 32 bits decremented modulo 2^32.
- R9: In the result cycle, zero_req has bit ack_idx set, and only that bit, exactly when a decrement mode left its field equal to zero. Otherwise zero_req is zero.
- R10: ack_mode 11 on counters 1 to 3 (ack_idx 0..2) returns ack_opnd unchanged, with no zero request and no exception.
- R11: ack_mode 11 on counter 4 (ack_idx 3) sets exc_flag for one cycle with the result. It returns ack_opnd unchanged and raises no zero request.
- R12: res_valid is high exactly in the cycle after a cycle with ack_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Asynchronous line-frequency pulse input |
| ext_in | input | 1 | Asynchronous external pulse input |
| src_sel | input | 6 | Source select, 2 bits per counter 1..3 |
| ack_valid | input | 1 | Service request for one counter this cycle |
| ack_idx | input | 2 | Counter being serviced (0..3) |
| ack_mode | input | 2 | 00 byte, 01 halfword, 10 word decrement, 11 pass-through |
| ack_opnd | input | 32 | Stored counter value to modify |
| pulse_req | output | 4 | One-cycle count-pulse request per counter |
| res_valid | output | 1 | Modified value is valid |
| res_data | output | 32 | Modified counter value |
| zero_req | output | 4 | One-cycle counter-equals-zero request per counter |
| exc_flag | output | 1 | Counter 4 serviced without a decrement |

## Verification
The zero request only fires when the field being decremented holds exactly one. Random 32-bit operands almost never reach that, so the stimulus biases about a third of its operands to carry 1 in the selected field. It also forces some operands to carry 0 there, which exercises the wrap without a zero request. A second hard case is exactly one tick per asynchronous pulse. To reach it, the bench drives bursts of random-width pulses on the line and external inputs while the counters watch mixed sources, and then compares the per-counter pulse totals.

// File: rtl/cpt_pkg.sv
// Shared encodings for the count-pulse timer.
// Assumes two-bit select and service-mode fields.
package cpt_pkg;
    typedef enum logic [1:0] {
        SRC_LINE = 2'b00,
        SRC_SLOW = 2'b01,
        SRC_FAST = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        SVC_BYTE = 2'b00,
        SVC_HALF = 2'b01,
        SVC_WORD = 2'b10,
        SVC_PASS = 2'b11
    } svc_e;
endpackage

// File: rtl/cpt_prescale.sv
// Divides the system clock down to a one-cycle tick every DIV cycles.
// Assumes DIV >= 1; the first tick comes DIV cycles after reset.
module cpt_prescale #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count to DIV-1, then wrap and emit a single tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    generate
        if (DIV > 1) begin : g_gap
            a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cpt_edge_sync.sv
// Brings an asynchronous pulse into the clock domain through two flops
// and emits one tick per rising edge. Assumes pulses last >= 2 cycles.
module cpt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic tick
);
    logic meta_q, sync_q, prev_q;

    // Two-stage synchronizer plus a history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising edge of the synchronized level.
    always_comb tick = sync_q & ~prev_q;

    a_r5_one_tick_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cpt_modtest.sv
// Combinational decrement-and-test on a byte, halfword or word field.
// Upper bits outside the field pass through; pass-through mode leaves the
// operand intact and flags an exception when the fixed counter is serviced.
module cpt_modtest
    import cpt_pkg::*;
#(
    parameter int DW = 32
) (
    input  svc_e          mode,
    input  logic          fixed_ctr,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] res,
    output logic          zero,
    output logic          exc
);
    localparam logic [DW-1:0] M_BYTE = DW'(8'hFF);
    localparam logic [DW-1:0] M_HALF = DW'(16'hFFFF);
    localparam logic [DW-1:0] M_WORD = '1;

    logic [DW-1:0] mask;
    logic [DW-1:0] dec;

    // Pick the field mask from the service mode.
    always_comb begin
        unique case (mode)
            SVC_BYTE: mask = M_BYTE;
            SVC_HALF: mask = M_HALF;
            SVC_WORD: mask = M_WORD;
            default:  mask = '0;
        endcase
    end

    // Decrement inside the field only and test the new field for zero.
    always_comb begin
        dec = opnd - 1'b1;
        if (mode == SVC_PASS) begin
            res  = opnd;
            zero = 1'b0;
            exc  = fixed_ctr;
        end else begin
            res  = (opnd & ~mask) | (dec & mask);
            zero = ((dec & mask) == '0);
            exc  = 1'b0;
        end
    end
endmodule

// File: rtl/cpt_timer.sv
// Count-pulse timer top: prescalers, input synchronizers, per-counter
// source routing and the registered decrement-and-test result.
// Assumes CLK_HZ is a multiple of 2000 and the last counter is fixed at 500 Hz.
module cpt_timer
    import cpt_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int N_CTR  = 4,
    parameter int DW     = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_in,
    input  logic                   ext_in,
    input  logic [2*(N_CTR-1)-1:0] src_sel,
    input  logic                   ack_valid,
    input  logic [1:0]             ack_idx,
    input  logic [1:0]             ack_mode,
    input  logic [DW-1:0]          ack_opnd,
    output logic [N_CTR-1:0]       pulse_req,
    output logic                   res_valid,
    output logic [DW-1:0]          res_data,
    output logic [N_CTR-1:0]       zero_req,
    output logic                   exc_flag
);
    localparam int DIV_SLOW = CLK_HZ / 500;
    localparam int DIV_FAST = CLK_HZ / 2000;
    localparam int N_SEL    = N_CTR - 1;

    logic tk_slow, tk_fast, tk_line, tk_ext;
    logic [N_CTR-1:0] tick_vec;
    logic [DW-1:0]    mt_res;
    logic             mt_zero, mt_exc;
    logic [N_CTR-1:0] zero_vec;

    cpt_prescale #(.DIV(DIV_SLOW)) u_slow (.clk(clk), .rst_n(rst_n), .tick(tk_slow));
    cpt_prescale #(.DIV(DIV_FAST)) u_fast (.clk(clk), .rst_n(rst_n), .tick(tk_fast));
    cpt_edge_sync u_line (.clk(clk), .rst_n(rst_n), .async_in(line_in), .tick(tk_line));
    cpt_edge_sync u_ext  (.clk(clk), .rst_n(rst_n), .async_in(ext_in),  .tick(tk_ext));

    generate
        for (genvar k = 0; k < N_SEL; k++) begin : g_route
            // Route the selected source to this counter.
            always_comb begin
                unique case (src_e'(src_sel[2*k +: 2]))
                    SRC_LINE: tick_vec[k] = tk_line;
                    SRC_SLOW: tick_vec[k] = tk_slow;
                    SRC_FAST: tick_vec[k] = tk_fast;
                    default:  tick_vec[k] = tk_ext;
                endcase
            end
        end
    endgenerate

    // The last counter is tied to the 500 Hz tick.
    always_comb tick_vec[N_CTR-1] = tk_slow;

    // Register the count-pulse requests as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_req <= '0;
        else        pulse_req <= tick_vec;
    end

    cpt_modtest #(.DW(DW)) u_mt (
        .mode      (svc_e'(ack_mode)),
        .fixed_ctr (ack_idx == 2'(N_CTR-1)),
        .opnd      (ack_opnd),
        .res       (mt_res),
        .zero      (mt_zero),
        .exc       (mt_exc)
    );

    // Decode the zero result onto the serviced counter's level.
    always_comb begin
        for (int i = 0; i < N_CTR; i++)
            zero_vec[i] = mt_zero && (ack_idx == 2'(i));
    end

    // Register the service result, zero requests and exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            zero_req  <= '0;
            exc_flag  <= 1'b0;
        end else begin
            res_valid <= ack_valid;
            res_data  <= ack_valid ? mt_res : '0;
            zero_req  <= ack_valid ? zero_vec : '0;
            exc_flag  <= ack_valid && mt_exc;
        end
    end

    a_r9_zero_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_req != '0) |-> res_valid);
    a_r9_zero_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(zero_req));
    a_r11_exc_only_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flag |-> (res_valid && zero_req == '0 && $past(ack_idx) == 2'(N_CTR-1)));
    a_r6_byte_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_valid) && $past(ack_mode) == 2'b00) |-> res_data[DW-1:8] == $past(ack_opnd[DW-1:8]));
    a_r10_pass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_valid) && $past(ack_mode) == 2'b11) |-> res_data == $past(ack_opnd));
    a_r12_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> res_valid);
endmodule

// File: tb/sim_cpt_timer.sv
module sim_cpt_timer;
    localparam int CLK_HZ = 40_000;
    localparam int D_SLOW = CLK_HZ / 500;
    localparam int D_FAST = CLK_HZ / 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b0, ext_in = 1'b0;
    logic [5:0]  src_sel = '0;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_idx = '0, ack_mode = '0;
    logic [31:0] ack_opnd = '0;
    logic [3:0]  pulse_req, zero_req;
    logic        res_valid, exc_flag;
    logic [31:0] res_data;

    int total = 0, bad = 0;
    logic        cnt_clr = 1'b0;
    int          pcnt [4];

    always #10 clk = ~clk;

    cpt_timer #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .ext_in(ext_in),
        .src_sel(src_sel), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .ack_mode(ack_mode), .ack_opnd(ack_opnd), .pulse_req(pulse_req),
        .res_valid(res_valid), .res_data(res_data), .zero_req(zero_req),
        .exc_flag(exc_flag)
    );

    // Pulse counters per request line.
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (cnt_clr) pcnt[i] <= 0;
            else if (pulse_req[i]) pcnt[i] <= pcnt[i] + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fmask(input logic [1:0] m);
        case (m)
            2'b00: return 32'h0000_00FF;
            2'b01: return 32'h0000_FFFF;
            2'b10: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_res(input logic [1:0] m, input logic [31:0] op);
        logic [31:0] mk = fmask(m);
        if (m == 2'b11) return op;
        return (op & ~mk) | (((op & mk) - 32'd1) & mk);
    endfunction

    function automatic logic [3:0] exp_zero(input logic [1:0] m, input logic [1:0] idx, input logic [31:0] op);
        logic [31:0] mk = fmask(m);
        if (m == 2'b11) return 4'b0;
        return ((op & mk) == 32'd1) ? (4'b1 << idx) : 4'b0;
    endfunction

    task automatic clear_counts();
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
    endtask

    task automatic measure(input int b, input int exp, input string tag);
        int n = 0;
        int guard = 0;
        while (!pulse_req[b] && guard < 2000) begin @(negedge clk); guard++; end
        do begin @(negedge clk); n++; end while (!pulse_req[b] && n < 2000);
        chk(n == exp, tag, n, exp);
    endtask

    task automatic pulse(input bit which, input int hi, input int lo);
        @(negedge clk);
        if (which) ext_in = 1'b1; else line_in = 1'b1;
        repeat (hi) @(negedge clk);
        if (which) ext_in = 1'b0; else line_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic do_ack(input logic [1:0] idx, input logic [1:0] m, input logic [31:0] op);
        logic [3:0] ez;
        @(negedge clk);
        ack_valid = 1'b1; ack_idx = idx; ack_mode = m; ack_opnd = op;
        @(negedge clk);
        ack_valid = 1'b0;
        ez = exp_zero(m, idx, op);
        chk(res_valid === 1'b1, "R12 res_valid", res_valid, 1);
        case (m)
            2'b00: chk(res_data === exp_res(m, op), "R6 byte result", res_data, exp_res(m, op));
            2'b01: chk(res_data === exp_res(m, op), "R7 half result", res_data, exp_res(m, op));
            2'b10: chk(res_data === exp_res(m, op), "R8 word result", res_data, exp_res(m, op));
            default: chk(res_data === op, "R10 pass result", res_data, op);
        endcase
        chk(zero_req === ez, "R9 zero_req", zero_req, ez);
        if (m == 2'b11 && idx == 2'd3)
            chk(exc_flag === 1'b1, "R11 exc set", exc_flag, 1);
        else
            chk(exc_flag === 1'b0, "R10 exc clear", exc_flag, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pulse_req === 4'b0 && zero_req === 4'b0, "R1 requests in reset", {pulse_req, zero_req}, 0);
        chk(res_valid === 1'b0 && exc_flag === 1'b0 && res_data === 32'b0, "R1 result in reset", res_data, 0);
        rst_n = 1'b1;

        // R2: fixed counter ignores select
        src_sel = 6'b111111;
        measure(3, D_SLOW, "R2 ctr4 period sel=3f");
        src_sel = 6'b000000;
        measure(3, D_SLOW, "R2 ctr4 period sel=00");

        // R4/R3: source routing of the fixed ticks
        src_sel = 6'b11_10_01;
        measure(0, D_SLOW, "R4 ctr1 on 500Hz");
        measure(1, D_FAST, "R3 ctr2 on 2000Hz");
        src_sel = 6'b01_11_10;
        measure(0, D_FAST, "R3 ctr1 on 2000Hz");
        measure(2, D_SLOW, "R4 ctr3 on 500Hz");
        clear_counts();
        repeat (200) @(negedge clk);
        chk(pcnt[1] == 0, "R4 ctr2 ext idle", pcnt[1], 0);

        // R5: one tick per asynchronous edge, random widths
        for (int rep = 0; rep < 3; rep++) begin
            int nl = $urandom_range(2, 7);
            int ne = $urandom_range(2, 7);
            src_sel = (rep == 1) ? 6'b11_00_11 : 6'b00_11_00;
            clear_counts();
            for (int p = 0; p < nl; p++) pulse(1'b0, $urandom_range(2, 5), $urandom_range(2, 6));
            for (int p = 0; p < ne; p++) pulse(1'b1, $urandom_range(2, 5), $urandom_range(2, 6));
            repeat (6) @(negedge clk);
            if (rep == 1) begin
                chk(pcnt[0] == ne, "R5 ctr1 ext count", pcnt[0], ne);
                chk(pcnt[1] == nl, "R5 ctr2 line count", pcnt[1], nl);
                chk(pcnt[2] == ne, "R5 ctr3 ext count", pcnt[2], ne);
            end else begin
                chk(pcnt[0] == nl, "R5 ctr1 line count", pcnt[0], nl);
                chk(pcnt[1] == ne, "R5 ctr2 ext count", pcnt[1], ne);
                chk(pcnt[2] == nl, "R5 ctr3 line count", pcnt[2], nl);
            end
        end

        // Directed corner cases of the decrement-and-test step
        do_ack(2'd0, 2'b00, 32'hABCD_EF01);  // R6 zero on byte
        do_ack(2'd1, 2'b00, 32'h1234_5600);  // R6 byte wrap, no borrow out
        do_ack(2'd2, 2'b01, 32'h7777_0001);  // R7 zero on halfword
        do_ack(2'd1, 2'b01, 32'h0001_0000);  // R7 halfword wrap
        do_ack(2'd3, 2'b10, 32'h0000_0001);  // R8 word zero on ctr4
        do_ack(2'd0, 2'b10, 32'h0000_0000);  // R8 word wrap
        do_ack(2'd2, 2'b11, 32'h0000_0001);  // R10 pass, no zero
        do_ack(2'd3, 2'b11, 32'hDEAD_BEEF);  // R11 exception

        // R12: no result without an ack
        @(negedge clk);
        chk(res_valid === 1'b0 && zero_req === 4'b0, "R12 idle no result", res_valid, 0);

        // Constrained random services
        for (int it = 0; it < 200; it++) begin
            logic [1:0]  idx = 2'($urandom_range(0, 3));
            logic [1:0]  m   = 2'($urandom_range(0, 3));
            logic [31:0] op  = $urandom;
            int sel = $urandom_range(0, 5);
            if (sel < 2) op = (op & ~fmask(m)) | 32'd1;
            else if (sel == 2) op = op & ~fmask(m);
            do_ack(idx, m, op);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule